// File: doc/BRIEF.md
# Six-Channel Reload Timer Bank

A bank of six independent 16-bit down-counters behind a small synchronous register bus. Each channel has a reload register and a 6-bit mode register. Channels are started and stopped through bits in two shared start registers. A running channel counts in one of two ways. In timer mode it counts ticks of one of four internal rates taken from a shared free-running prescaler. In event mode it counts qualified edges of its own external input, which first passes through a two-flop synchronizer.

When a running channel takes a tick while its count is zero, the count is refilled from the reload register, and a one-cycle underflow pulse is raised for that channel. Software sets the mode and initial value while the channel is stopped, then sets the start bit. The count can be read at any time while the channel runs. A read issued in the same cycle as a refill returns all ones. A mode register cannot be changed while its channel is counting.

Top module: `tmr_bank`

Register map (4-bit address; read data appears on `bus_rdata_o` in the cycle after the read strobe):
- 0..5: counter/reload register of channels 0..5.
- 6..11: mode register of channels 0..5. Bits [1:0] hold the operation (00 timer, 01 event, 10 and 11 hold). Bits [3:2] select the timer rate. Bits [5:4] select the edge: 00 rising, 01 falling, 10 or 11 both.
- 12: start register A. Bits 5, 6 and 7 start channels 0, 1 and 2.
- 13: start register B. Bits 5, 6 and 7 start channels 3, 4 and 5.
- All other bits and addresses read as zero, and writes to them have no effect.

## Requirements
- R1: After reset every channel is stopped and its underflow output is low. Every counter, mode and start register reads zero.
- R2: Start bits sit in bits 5..7 of address 12 for channels 0..2 and in bits 5..7 of address 13 for channels 3..5. Writing 1 starts a channel and writing 0 stops it. A read returns the run state in those same bit positions.
- R3: A mode register write while its channel runs is ignored, and the mode read-back is unchanged.
- R4: While a channel runs, a read of its counter register returns the count held before that clock edge, and the read does not disturb counting.
- R5: A counter register read in the cycle in which that channel refills returns 16'hFFFF, in both timer and event modes.
- R6: A counter write while the channel is stopped sets both the reload value and the count, so a following read returns the written value. A 0-to-1 start bit loads the count from the reload value.
- R7: A counter write while the channel runs updates only the reload value. The live count keeps counting and takes the new value only at the next refill.
- R8: In timer mode the count drops by one per tick of the selected rate. Rate 0 ticks every cycle. Rates 1, 2 and 3 tick once every 2^SRC1_LOG2, 2^SRC2_LOG2 and 2^SRC3_LOG2 cycles, when the low bits of a prescaler that starts at zero on reset and increments every cycle are all zero.
- R9: A tick while the count is zero refills the count from the reload value. The channel's underflow output is then high for exactly the next cycle.
- R10: In event mode an input change counts as a tick two cycles after it is first sampled, with at most one tick per cycle. The tick is taken on the rising edge, the falling edge, or both, as the edge field selects.
- R11: Operation codes 10 and 11 never count, even when the channel is started.
- R12: Stopping a channel freezes its count. Restarting it reloads the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after bus_re_i |
| evt_i | input | 6 | Asynchronous event inputs, one per channel |
| uf_o | output | 6 | One-cycle underflow pulses, one per channel |

## Verification
A wrong count or a wrong reload value in a channel shows up at the ports only when the channel is read or when it underflows. For this reason the bench reads counters repeatedly and compares every cycle of `uf_o` against a cycle-accurate reference model, which catches a drift within one refill period. Mode-lock and start-mapping faults show up on the next read of the mode or start register. Errors in synchronizer latency or edge selection show up as a count that is off by one, or as an underflow pulse one cycle early or late.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH         = 6;
  localparam int CNT_W          = 16;
  localparam int MODE_W         = 6;
  localparam int ADDR_W         = 4;
  localparam int NUM_SRC        = 4;
  localparam int ADDR_MODE_BASE = 6;
  localparam int ADDR_START_A   = 12;
  localparam int ADDR_START_B   = 13;
  localparam int START_BIT_LO   = 5;
  localparam int CH_PER_START   = 3;

  typedef enum logic [1:0] {
    OP_TIMER = 2'b00,
    OP_EVENT = 2'b01,
    OP_HOLD2 = 2'b10,
    OP_HOLD3 = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e  edge_sel;  // [5:4]
    logic [1:0] src_sel;   // [3:2]
    op_mode_e   op;        // [1:0]
  } mode_reg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SRC1_LOG2 = 3,
  parameter int SRC2_LOG2 = 5,
  parameter int SRC3_LOG2 = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [3:0] tick_o
);
  localparam int PRE_W = (SRC3_LOG2 > SRC2_LOG2) ?
                         ((SRC3_LOG2 > SRC1_LOG2) ? SRC3_LOG2 : SRC1_LOG2) :
                         ((SRC2_LOG2 > SRC1_LOG2) ? SRC2_LOG2 : SRC1_LOG2);
  localparam int LOG2_TAB [4] = '{0, SRC1_LOG2, SRC2_LOG2, SRC3_LOG2};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k < 4; k++) begin : g_tick
    assign tick_o[k] = (pre_q[LOG2_TAB[k]-1:0] == '0);
  end
endmodule

// File: rtl/tmr_evt_edge.sv
module tmr_evt_edge #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= evt_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic              evt_rise_i,
  input  logic              evt_fall_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              start_we_i,
  input  logic              start_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              reload_now_o,
  output logic              uf_o
);
  mode_reg_t        mode_q;
  logic             run_q, uf_q;
  logic [CNT_W-1:0] cnt_q, rel_q;
  logic             edge_hit, tick;

  always_comb begin
    unique case (mode_q.edge_sel)
      EDGE_RISE: edge_hit = evt_rise_i;
      EDGE_FALL: edge_hit = evt_fall_i;
      default:   edge_hit = evt_rise_i | evt_fall_i;
    endcase
  end

  always_comb begin
    tick = 1'b0;
    if (run_q) begin
      unique case (mode_q.op)
        OP_TIMER: tick = src_tick_i[mode_q.src_sel];
        OP_EVENT: tick = edge_hit;
        default:  tick = 1'b0;
      endcase
    end
  end

  assign reload_now_o = tick && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rel_q  <= '0;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= reload_now_o;
      if (mode_we_i && !run_q) mode_q <= mode_reg_t'(mode_wdata_i);
      if (cnt_we_i) rel_q <= cnt_wdata_i;
      if (start_we_i) run_q <= start_i;
      if (start_we_i && start_i && !run_q)  cnt_q <= rel_q;
      else if (cnt_we_i && !run_q)          cnt_q <= cnt_wdata_i;
      else if (reload_now_o)                cnt_q <= rel_q;
      else if (tick)                        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign uf_o   = uf_q;

  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(mode_q)); // R3
  AST_UF_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> ($past(cnt_q) == '0 && $past(run_q))); // R9
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (cnt_q == $past(rel_q))); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !$past(run_q) && !$past(cnt_we_i)) |-> $stable(cnt_q)); // R12
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int SRC1_LOG2 = 3,
  parameter int SRC2_LOG2 = 5,
  parameter int SRC3_LOG2 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [NUM_CH-1:0] evt_i,
  output logic [NUM_CH-1:0] uf_o
);
  logic [NUM_SRC-1:0] src_tick;
  logic [NUM_CH-1:0]  rise, fall, run, reload_now;
  logic [NUM_CH-1:0]  cnt_we, mode_we, start_we, start_bit;
  logic [CNT_W-1:0]   cnt  [NUM_CH];
  logic [MODE_W-1:0]  mode [NUM_CH];
  logic [CNT_W-1:0]   rd_val, rdata_q;

  tmr_prescaler #(
    .SRC1_LOG2(SRC1_LOG2), .SRC2_LOG2(SRC2_LOG2), .SRC3_LOG2(SRC3_LOG2)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(src_tick)
  );

  tmr_evt_edge #(.N(NUM_CH)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .rise_o(rise), .fall_o(fall)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int START_ADDR = (i < CH_PER_START) ? ADDR_START_A : ADDR_START_B;
    localparam int START_POS  = START_BIT_LO + (i % CH_PER_START);

    assign cnt_we[i]    = bus_we_i && (bus_addr_i == ADDR_W'(i));
    assign mode_we[i]   = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_MODE_BASE + i));
    assign start_we[i]  = bus_we_i && (bus_addr_i == ADDR_W'(START_ADDR));
    assign start_bit[i] = bus_wdata_i[START_POS];

    tmr_channel u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .src_tick_i(src_tick),
      .evt_rise_i(rise[i]), .evt_fall_i(fall[i]),
      .cnt_we_i(cnt_we[i]), .cnt_wdata_i(bus_wdata_i),
      .mode_we_i(mode_we[i]), .mode_wdata_i(bus_wdata_i[MODE_W-1:0]),
      .start_we_i(start_we[i]), .start_i(start_bit[i]),
      .run_o(run[i]), .cnt_o(cnt[i]), .mode_o(mode[i]),
      .reload_now_o(reload_now[i]), .uf_o(uf_o[i])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr_i == ADDR_W'(i))
        rd_val = reload_now[i] ? '1 : cnt[i];
      if (bus_addr_i == ADDR_W'(ADDR_MODE_BASE + i))
        rd_val = CNT_W'(mode[i]);
    end
    if (bus_addr_i == ADDR_W'(ADDR_START_A))
      rd_val[START_BIT_LO +: CH_PER_START] = run[CH_PER_START-1:0];
    if (bus_addr_i == ADDR_W'(ADDR_START_B))
      rd_val[START_BIT_LO +: CH_PER_START] = run[NUM_CH-1:CH_PER_START];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_re_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;

  AST_RELOAD_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i < ADDR_W'(NUM_CH) && (|(reload_now & (NUM_CH'(1) << bus_addr_i))))
    |=> (bus_rdata_o == '1)); // R5
  AST_RUN_NEEDS_START_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((run != $past(run)) |-> $past(bus_we_i))); // R2
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  localparam int L1 = 3, L2 = 5, L3 = 7;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  evt = '0;
  logic [5:0]  uf;

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  tmr_bank #(.SRC1_LOG2(L1), .SRC2_LOG2(L2), .SRC3_LOG2(L3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .evt_i(evt), .uf_o(uf)
  );

  always #10 clk = ~clk;  // 50 MHz

  // reference model
  logic        m_run [NCH];
  logic [15:0] m_cnt [NCH], m_rel [NCH];
  logic [5:0]  m_mode [NCH];
  logic [5:0]  m_s1, m_s2, m_p, m_uf;
  int unsigned m_pre;
  logic [15:0] m_rd;
  logic        m_chk;
  string       m_tag;

  function automatic logic src_tick(int unsigned pre, logic [1:0] s);
    case (s)
      2'd0: return 1'b1;
      2'd1: return (pre % (1 << L1)) == 0;
      2'd2: return (pre % (1 << L2)) == 0;
      default: return (pre % (1 << L3)) == 0;
    endcase
  endfunction

  function automatic logic edge_tick(logic [1:0] es, logic r, logic f);
    if (es == 2'b00) return r;
    if (es == 2'b01) return f;
    return r | f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_run[i] = 0; m_cnt[i] = 0; m_rel[i] = 0; m_mode[i] = 0;
      end
      m_s1 = 0; m_s2 = 0; m_p = 0; m_uf = 0; m_pre = 0; m_rd = 0; m_chk = 0;
      m_tag = "R1";
    end else begin
      logic [5:0] tk, rl, rise, fall;
      rise = m_s2 & ~m_p;
      fall = ~m_s2 & m_p;
      for (int i = 0; i < NCH; i++) begin
        tk[i] = 0;
        if (m_run[i]) begin
          if (m_mode[i][1:0] == 2'b00) tk[i] = src_tick(m_pre, m_mode[i][3:2]);
          else if (m_mode[i][1:0] == 2'b01) tk[i] = edge_tick(m_mode[i][5:4], rise[i], fall[i]);
        end
        rl[i] = tk[i] && m_cnt[i] == 0;
      end
      m_chk = re;
      if (re) begin
        logic [15:0] v;
        v = 0;
        m_tag = cur_tag;
        if (addr < 6) begin
          v = rl[addr] ? 16'hFFFF : m_cnt[addr];
          if (rl[addr]) m_tag = "R5";
        end else if (addr < 12) v = {10'd0, m_mode[addr-6]};
        else if (addr == 12) v[7:5] = {m_run[2], m_run[1], m_run[0]};
        else if (addr == 13) v[7:5] = {m_run[5], m_run[4], m_run[3]};
        m_rd = v;
      end
      for (int i = 0; i < NCH; i++) begin
        logic sw, sv;
        sw = we && ((i < 3 && addr == 12) || (i >= 3 && addr == 13));
        sv = wdata[5 + (i % 3)];
        if (we && addr == 4'(6 + i) && !m_run[i]) m_mode[i] = wdata[5:0];
        if (sw && sv && !m_run[i]) m_cnt[i] = m_rel[i];
        else if (we && addr == 4'(i) && !m_run[i]) m_cnt[i] = wdata;
        else if (rl[i]) m_cnt[i] = m_rel[i];
        else if (tk[i]) m_cnt[i] = m_cnt[i] - 1;
        if (we && addr == 4'(i)) m_rel[i] = wdata;
        if (sw) m_run[i] = sv;
      end
      m_uf = rl;
      m_p = m_s2; m_s2 = m_s1; m_s1 = evt;
      m_pre = m_pre + 1;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R9", {10'd0, uf}, {10'd0, m_uf});
      if (m_chk) check(m_tag, rdata, m_rd);
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [3:0] a);
    re = 1; addr = a;
    @(negedge clk);
    re = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_tag = "R1";
    check("R1", {10'd0, uf}, 16'd0);
    for (int a = 0; a < 14; a++) rd(4'(a));
    // R6 write stopped, read back
    cur_tag = "R6";
    wr(0, 16'd4); rd(0);
    wr(6, 16'h0000);           // ch0 timer, rate 0
    // R2 start ch0 only via reg A bit5
    cur_tag = "R2";
    wr(12, 16'h0020); rd(12); rd(13);
    // R4/R5/R9 live reads every cycle across refills
    cur_tag = "R4";
    for (int k = 0; k < 14; k++) rd(0);
    // R7 write while running: reload only
    cur_tag = "R7";
    wr(0, 16'd9); rd(0); rd(0);
    idle(3); for (int k = 0; k < 12; k++) rd(0);
    // R3 mode write ignored while running
    cur_tag = "R3";
    wr(6, 16'h0001); rd(6);
    // R12 stop holds, restart reloads
    cur_tag = "R12";
    wr(12, 16'h0000); rd(0); idle(5); rd(0);
    wr(12, 16'h0020); rd(0);
    wr(12, 16'h0000);
    // R8 ch1 rate 1 and ch2 rate 2
    cur_tag = "R8";
    wr(7, 16'h0004); wr(8, 16'h0008);
    wr(1, 16'd3); wr(2, 16'd1);
    wr(12, 16'h00C0);
    for (int k = 0; k < 40; k++) begin rd(1); rd(2); end
    wr(12, 16'h0000);
    // R10 event mode, each edge select
    cur_tag = "R10";
    wr(9, 16'h0021); wr(10, 16'h0001); wr(11, 16'h0011);
    wr(3, 16'd2); wr(4, 16'd2); wr(5, 16'd2);
    wr(13, 16'h00E0);
    for (int k = 0; k < 10; k++) begin
      evt[5:3] = ~evt[5:3]; rd(3); rd(4); rd(5); idle(k % 3);
    end
    evt[4] = ~evt[4]; for (int k = 0; k < 5; k++) rd(4);  // R5 in event mode
    wr(13, 16'h0000);
    // R11 hold opcodes
    cur_tag = "R11";
    wr(9, 16'h0002); wr(10, 16'h0003); wr(3, 16'd5); wr(4, 16'd5);
    wr(13, 16'h0060); idle(20); rd(3); rd(4);
    wr(13, 16'h0000);
    // random phase
    cur_tag = "R4";
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      r = $urandom % 100;
      if (($urandom % 4) == 0) evt = 6'($urandom);
      if (r < 25) begin
        logic [3:0] a;
        logic [15:0] d;
        a = 4'($urandom % 14);
        if (a < 6) d = 16'($urandom % 12);
        else if (a < 12) d = 16'($urandom % 64);
        else d = 16'($urandom);
        wr(a, d);
      end else if (r < 60) begin
        rd(4'($urandom % 16));
      end else begin
        idle(1);
      end
    end
    idle(3);
    finish_run();
  end
endmodule